// File: doc/BRIEF.md
# Fixed-Off-Time Bridge Current Chopper

This block is the digital controller for one H-bridge that drives a brushed DC motor. From a direction bit, a modulation bit and an enable bit it decodes which of the four power switches conduct: two high-side and two low-side, one pair per leg. It reports a high-impedance flag for each leg when the bridge is released. A synchronous flag from an external current comparator tells the block that the sensed current has risen above its reference. When that happens, the controller stops following its command inputs. It holds both low-side switches on (slow decay) for an off interval, given in clock cycles, and then goes back to normal decoding.

Every gate command passes through a per-leg guard. The guard turns a switch off at once. It turns a switch on only after the leg has had both switches off for a fixed number of cycles. So the two switches of one leg never conduct together, whether the change comes from the inputs, from entering decay or from leaving it. The controller has three states. ST_IDLE means the bridge is released. ST_DRIVE means the inputs are decoded. ST_DECAY means the off interval is running. Its transitions are: IDLE to DRIVE when enable rises; DRIVE to DECAY on a comparator trip; DECAY to DRIVE when the off count runs out; and any state to IDLE when enable falls.

Top module: `bridge_chopper`

## Requirements
- R1: While `enable` is low, and during reset, all four gate outputs are 0 and `hiz1` and `hiz2` are 1, for any `phase` and `pwm`. A falling `enable` reaches the outputs one clock after it is sampled.
- R2: With `enable` high, no trip active and `pwm` low, `ls1` and `ls2` are 1 and `hs1` and `hs2` are 0, for `phase` 0 and for `phase` 1 (brake).
- R3: With `enable` high, no trip active and `pwm` high, `phase` 0 gives `hs2`=1 and `ls1`=1, and `phase` 1 gives `hs1`=1 and `ls2`=1. The other gates are 0 and both hiz flags are 0.
- R4: When `over_ref` is sampled high in ST_DRIVE, the next edge enters ST_DECAY. The decay state lasts exactly `off_cycles` cycles and then returns to ST_DRIVE. During decay, both legs are requested low-side on. A value of 0 acts as 1.
- R5: During ST_DECAY, changes on `phase`, `pwm` and `over_ref` have no effect on the outputs.
- R6: `off_cycles` is captured when decay starts. A new value written during decay first applies at the next trip.
- R7: If `over_ref` is still high when decay ends, exactly one ST_DRIVE cycle is decoded, and then a new decay period starts.
- R8: A low `enable` during decay aborts it. The bridge tri-states one clock later, and the off count is cleared. After `enable` returns, normal decoding resumes without any leftover decay.
- R9: `hs1` and `ls1` are never 1 in the same cycle, and neither are `hs2` and `ls2`.
- R10: A gate of a leg turns on only after that leg has had both gates at 0 for DEAD_CYC consecutive cycles. A swap from one switch to its complement shows both gates at 0 for exactly DEAD_CYC cycles. A turn-off, or a change that needs no wait, appears one clock after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Bridge enable; low releases the bridge |
| phase | input | 1 | Current direction select |
| pwm | input | 1 | Modulation input; low brakes |
| over_ref | input | 1 | Synchronous flag: sensed current above reference |
| off_cycles | input | OFF_W | Decay length in clock cycles (0 acts as 1) |
| hs1 | output | 1 | Leg 1 high-side gate command |
| ls1 | output | 1 | Leg 1 low-side gate command |
| hs2 | output | 1 | Leg 2 high-side gate command |
| ls2 | output | 1 | Leg 2 low-side gate command |
| hiz1 | output | 1 | Leg 1 high-impedance flag |
| hiz2 | output | 1 | Leg 2 high-impedance flag |

## Verification
The case that matters most is the end of a decay period while the comparator flag is still high. In that cycle, the return to decoding and a new trip arrive together. The leg that was braking sees a one-cycle drive request and then a new decay request, all while its dead-time guard is still counting. The bench holds `over_ref` high across the expiry and samples the cycle in which a single expiry would already have turned the high side on. There it expects the low side to be back on and the high side still off.

A second collision is a fall of `enable` in the middle of decay. That case is judged on the cycle after re-enable: plain decoding must appear there and not the rest of the off interval.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRIVE = 2'd1,
        ST_DECAY = 2'd2
    } chop_state_t;

    typedef struct packed {
        logic hs;
        logic ls;
    } leg_cmd_t;

    localparam int NUM_LEGS = 2;

endpackage

// File: rtl/chop_fsm.sv
module chop_fsm
    import bridge_pkg::*;
#(
    parameter int OFF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             over_ref,
    input  logic [OFF_W-1:0] off_cycles,
    output chop_state_t      state
);

    localparam logic [OFF_W-1:0] ONE = OFF_W'(1);

    chop_state_t      state_q;
    chop_state_t      state_d;
    logic [OFF_W-1:0] cnt_q;
    logic             start_decay;

    // next-state process
    always_comb begin
        state_d     = state_q;
        start_decay = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (enable) state_d = ST_DRIVE;
            end
            ST_DRIVE: begin
                if (!enable) begin
                    state_d = ST_IDLE;
                end else if (over_ref) begin
                    state_d     = ST_DECAY;
                    start_decay = 1'b1;
                end
            end
            ST_DECAY: begin
                if (!enable)          state_d = ST_IDLE;
                else if (cnt_q <= ONE) state_d = ST_DRIVE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // off-time counter, loaded when decay begins
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt_q <= '0;
        end else if (start_decay) begin
            cnt_q <= (off_cycles == '0) ? ONE : off_cycles;
        end else if (state_q == ST_DECAY && cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/bridge_decode.sv
module bridge_decode
    import bridge_pkg::*;
(
    input  logic        enable,
    input  chop_state_t state,
    input  logic        phase,
    input  logic        pwm,
    output leg_cmd_t    cmd [NUM_LEGS],
    output logic        hiz_req
);

    always_comb begin
        cmd[0]  = '0;
        cmd[1]  = '0;
        hiz_req = 1'b0;
        if (!enable) begin
            hiz_req = 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: hiz_req = 1'b1;
                ST_DRIVE: begin
                    if (!pwm) begin
                        cmd[0].ls = 1'b1;
                        cmd[1].ls = 1'b1;
                    end else if (phase) begin
                        cmd[0].hs = 1'b1;
                        cmd[1].ls = 1'b1;
                    end else begin
                        cmd[1].hs = 1'b1;
                        cmd[0].ls = 1'b1;
                    end
                end
                ST_DECAY: begin
                    cmd[0].ls = 1'b1;
                    cmd[1].ls = 1'b1;
                end
                default: hiz_req = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/leg_deadtime.sv
module leg_deadtime
    import bridge_pkg::*;
#(
    parameter int DEAD_CYC = 5
) (
    input  logic     clk,
    input  logic     rst_n,
    input  leg_cmd_t req,
    input  logic     hiz_req,
    output logic     hs,
    output logic     ls,
    output logic     hiz
);

    localparam int            CW       = $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] GAP_LAST = CW'(DEAD_CYC - 1);

    logic          hs_q, ls_q, hiz_q;
    logic          hs_d, ls_d;
    logic [CW-1:0] idle_q;

    // turn-offs pass at once; turn-ons wait for a full gap
    always_comb begin
        hs_d = hs_q & req.hs;
        ls_d = ls_q & req.ls;
        if (!hs_q && !ls_q && idle_q == GAP_LAST) begin
            hs_d = req.hs;
            ls_d = req.ls & ~req.hs;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q   <= 1'b0;
            ls_q   <= 1'b0;
            hiz_q  <= 1'b1;
            idle_q <= GAP_LAST;
        end else begin
            hs_q  <= hs_d;
            ls_q  <= ls_d;
            hiz_q <= hiz_req;
            if (hs_q || ls_q)          idle_q <= '0;
            else if (idle_q != GAP_LAST) idle_q <= idle_q + CW'(1);
        end
    end

    assign hs  = hs_q;
    assign ls  = ls_q;
    assign hiz = hiz_q;

endmodule

// File: rtl/bridge_chopper.sv
module bridge_chopper
    import bridge_pkg::*;
#(
    parameter int OFF_W    = 16,
    parameter int DEAD_CYC = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             phase,
    input  logic             pwm,
    input  logic             over_ref,
    input  logic [OFF_W-1:0] off_cycles,
    output logic             hs1,
    output logic             ls1,
    output logic             hs2,
    output logic             ls2,
    output logic             hiz1,
    output logic             hiz2
);

    chop_state_t state;
    leg_cmd_t    cmd [NUM_LEGS];
    logic        hiz_req;
    logic        hs_o  [NUM_LEGS];
    logic        ls_o  [NUM_LEGS];
    logic        hiz_o [NUM_LEGS];

    chop_fsm #(.OFF_W(OFF_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .over_ref   (over_ref),
        .off_cycles (off_cycles),
        .state      (state)
    );

    bridge_decode u_dec (
        .enable  (enable),
        .state   (state),
        .phase   (phase),
        .pwm     (pwm),
        .cmd     (cmd),
        .hiz_req (hiz_req)
    );

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        leg_deadtime #(.DEAD_CYC(DEAD_CYC)) u_leg (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (cmd[g]),
            .hiz_req (hiz_req),
            .hs      (hs_o[g]),
            .ls      (ls_o[g]),
            .hiz     (hiz_o[g])
        );
    end

    assign hs1  = hs_o[0];
    assign ls1  = ls_o[0];
    assign hiz1 = hiz_o[0];
    assign hs2  = hs_o[1];
    assign ls2  = ls_o[1];
    assign hiz2 = hiz_o[1];

endmodule

// File: rtl/bridge_chopper_chk.sv
module bridge_chopper_chk #(
    parameter int DEAD_CYC = 5
) (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic hs1,
    input logic ls1,
    input logic hs2,
    input logic ls2,
    input logic hiz1,
    input logic hiz2
);

    localparam int            CW  = $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] SAT = CW'(DEAD_CYC);

    logic [CW-1:0] gap1, gap2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap1 <= SAT;
            gap2 <= SAT;
        end else begin
            if (hs1 || ls1)      gap1 <= '0;
            else if (gap1 != SAT) gap1 <= gap1 + CW'(1);
            if (hs2 || ls2)      gap2 <= '0;
            else if (gap2 != SAT) gap2 <= gap2 + CW'(1);
        end
    end

    // R9
    leg1_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs1 && ls1));
    // R9
    leg2_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs2 && ls2));
    // R10
    leg1_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hs1) || $rose(ls1)) |-> (gap1 == SAT));
    // R10
    leg2_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hs2) || $rose(ls2)) |-> (gap2 == SAT));
    // R1
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (hiz1 && hiz2 && !hs1 && !ls1 && !hs2 && !ls2));
    // R1
    hiz_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hiz1 || hiz2) |-> !(hs1 || ls1 || hs2 || ls2));

endmodule

bind bridge_chopper bridge_chopper_chk #(.DEAD_CYC(DEAD_CYC)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .hs1    (hs1),
    .ls1    (ls1),
    .hs2    (hs2),
    .ls2    (ls2),
    .hiz1   (hiz1),
    .hiz2   (hiz2)
);

// File: tb/sim_bridge_chopper.sv
module sim_bridge_chopper;

    localparam int OFF_W = 16;
    localparam int DEAD  = 5;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             enable, phase, pwm, over_ref;
    logic [OFF_W-1:0] off_cycles;
    logic             hs1, ls1, hs2, ls2, hiz1, hiz2;

    int  tests = 0;
    int  fails = 0;
    bit  done  = 1'b0;

    always #5 clk = ~clk;

    bridge_chopper #(.OFF_W(OFF_W), .DEAD_CYC(DEAD)) u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .phase(phase), .pwm(pwm),
        .over_ref(over_ref), .off_cycles(off_cycles),
        .hs1(hs1), .ls1(ls1), .hs2(hs2), .ls2(ls2), .hiz1(hiz1), .hiz2(hiz2)
    );

    // {en, ph, pwm} -> {hs1, ls1, hs2, ls2, hiz1, hiz2}
    localparam logic [8:0] VEC [10] = '{
        {3'b000, 6'b000011},
        {3'b011, 6'b000011},
        {3'b100, 6'b010100},
        {3'b111, 6'b100100},
        {3'b101, 6'b011000},
        {3'b110, 6'b010100},
        {3'b010, 6'b000011},
        {3'b111, 6'b100100},
        {3'b101, 6'b011000},
        {3'b111, 6'b100100}
    };

    function automatic logic [5:0] outs();
        return {hs1, ls1, hs2, ls2, hiz1, hiz2};
    endfunction

    task automatic check(input string req, input logic [5:0] exp);
        logic [5:0] act;
        act = outs();
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; enable = 1'b0; phase = 1'b1; pwm = 1'b1;
        over_ref = 1'b0; off_cycles = OFF_W'(20);
        tick(3);
        check("R1 in reset", 6'b000011);
        rst_n = 1'b1;
        tick(2);
        check("R1 after reset", 6'b000011);

        // table walk
        for (int i = 0; i < 10; i++) begin
            enable = VEC[i][8]; phase = VEC[i][7]; pwm = VEC[i][6];
            tick(12);
            if (!VEC[i][8])     check("R1 vector", VEC[i][5:0]);
            else if (!VEC[i][6]) check("R2 vector", VEC[i][5:0]);
            else                 check("R3 vector", VEC[i][5:0]);
        end

        // R10 swap phase 0 -> 1 with exact gap
        phase = 1'b0; tick(12);
        check("R3 pre-swap", 6'b011000);
        phase = 1'b1;
        tick(1);  check("R10 off at once", 6'b000000);
        tick(DEAD - 1); check("R10 still off", 6'b000000);
        tick(1);  check("R10 on after gap", 6'b100100);

        // trip, inputs ignored, off time captured
        off_cycles = OFF_W'(20); over_ref = 1'b1;
        tick(1); over_ref = 1'b0;                         // after E1
        tick(1); check("R4 high side off", 6'b000100);    // E2
        tick(DEAD); check("R4 decay both low", 6'b010100); // E7
        phase = 1'b0; pwm = 1'b1; off_cycles = OFF_W'(100); over_ref = 1'b1;
        tick(1); over_ref = 1'b0;
        tick(12); check("R5 inputs ignored at E20", 6'b010100);
        tick(1); check("R5 still decay at E21", 6'b010100);
        tick(1); check("R6 decay ended after captured count", 6'b010000);
        tick(DEAD); check("R6 drive resumes", 6'b011000);

        // retrigger with comparator held high
        tick(12);
        off_cycles = OFF_W'(10); over_ref = 1'b1;
        tick(1);                                           // E1
        tick(1); check("R7 high side off", 6'b010000);      // E2
        tick(DEAD); check("R7 first decay", 6'b010100);     // E7
        tick(5); check("R7 single drive cycle", 6'b010000); // E12
        tick(DEAD); check("R7 second decay", 6'b010100);    // E17
        over_ref = 1'b0;
        tick(1); check("R7 no high side", 6'b010100);

        // abort during decay
        tick(40);
        check("R3 before abort", 6'b011000);
        off_cycles = OFF_W'(30); over_ref = 1'b1;
        tick(1); over_ref = 1'b0;
        tick(3);
        enable = 1'b0; phase = 1'b1; pwm = 1'b1;
        tick(1); check("R8 abort tri-states", 6'b000011);
        tick(5);
        enable = 1'b1;
        tick(1); check("R8 still released", 6'b000011);
        tick(1); check("R8 no leftover decay", 6'b100100);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule